// File: doc/BRIEF.md
# Prescaled PWM Time-Base Counter

This block is the time base of a PWM generator. A two-stage prescaler divides the system clock into an advance strobe. On each strobe the counter moves one step in the selected counting mode. There are four modes: count up, count down, count up then down, and hold. The block outputs the counter value and a direction flag. It also outputs single-cycle strobes for "counter at zero" and "counter at period", which downstream compare and output logic use.

A 16-bit control word sets the counting mode, the two prescaler fields and the period-load policy. A separate write strobe supplies the period. In shadow mode a period write goes to a holding register, which is copied into the active period at the next zero event. In immediate mode the write goes straight into the active period.

Top module: `pwm_timebase`

## Requirements
- R1: After reset `cnt` is 0, `dir_up` is 1, both event strobes are 0, the mode is hold, the active and held periods are 0, and both prescaler fields are 0.
- R2: Control word fields are: mode at bits 1:0, period-load select at bit 3, divider field H at bits 9:7, divider field C at bits 12:10. `tick` pulses once every R clocks, where R = 2^C × (H == 0 ? 1 : 2·H). R ranges from 1 to 1792.
- R3: A control write restarts the prescaler. The first `tick` after the write comes in the R-th cycle following the write edge.
- R4: Mode 00 (up): on each tick the counter increments. When it is at or above the active period, it wraps to 0 on the next tick instead. `dir_up` is 1.
- R5: Mode 01 (down): on each tick the counter decrements. From 0 it reloads the active period. `dir_up` is 0.
- R6: Mode 10 (up-down): the counter climbs to the active period and then descends to 0. `dir_up` falls when the top is reached and rises again at 0.
- R7: Mode 11 (hold): the counter and `dir_up` keep their values, and no event strobe is raised.
- R8: With bit 3 = 0, a period write is held back. It becomes the active period at the edge ending the next zero-event cycle.
- R9: With bit 3 = 1, a period write becomes the active period at that same edge.
- R10: If a shadow-mode period write falls in a zero-event cycle, the new value, not the older held one, becomes active at that edge.
- R11: `evt_zero` is high only in a tick cycle with `cnt` = 0. `evt_prd` is high only in a tick cycle with `cnt` equal to the active period. Both are low in hold mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word |
| prd_we | input | 1 | Period write strobe |
| prd_wdata | input | CNT_W | Period value |
| tick | output | 1 | Prescaled advance strobe |
| cnt | output | CNT_W | Counter value |
| dir_up | output | 1 | 1 while counting upward |
| evt_zero | output | 1 | Zero-match strobe |
| evt_prd | output | 1 | Period-match strobe |

## Verification
The collision of interest is a shadow-mode period write landing in the same cycle as the zero event that copies the held period into the active one. The bench watches its reference model for a predicted zero event and drives the period write in exactly that cycle. It then confirms that the counter's later tops follow the freshly written value rather than the stale held one. The same model is compared with every output on every clock, so the transfer edge and the first wrap after it are both judged.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;
   typedef enum logic [1:0] {
      MODE_UP   = 2'b00,
      MODE_DOWN = 2'b01,
      MODE_UPDN = 2'b10,
      MODE_HOLD = 2'b11
   } tb_mode_e;

   localparam int CTRL_W   = 16;
   localparam int MODE_LSB = 0;
   localparam int LOAD_BIT = 3;
   localparam int HS_LSB   = 7;
   localparam int CK_LSB   = 10;
   localparam int DIV_W    = 3;
endpackage

// File: rtl/pwm_tb_prescaler.sv
module pwm_tb_prescaler #(
   parameter int DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [DIV_W-1:0] ck_sel,
   input  logic [DIV_W-1:0] hs_sel,
   output logic             tick
);
   localparam int MAX_SHIFT = (1 << DIV_W) - 1;
   localparam int MAX_LIN   = 2 * ((1 << DIV_W) - 1);
   localparam int PS_W      = MAX_SHIFT + $clog2(MAX_LIN + 1) + 1;

   logic [PS_W-1:0] ratio;
   logic [PS_W-1:0] pcnt;

   always_comb begin
      if (hs_sel == '0) ratio = PS_W'(1);
      else              ratio = PS_W'({hs_sel, 1'b0});
      ratio = ratio << ck_sel;
   end

   assign tick = (pcnt == ratio - PS_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pcnt <= '0;
      else if (restart) pcnt <= '0;
      else if (tick)    pcnt <= '0;
      else              pcnt <= pcnt + PS_W'(1);
   end

   assert_restart_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (pcnt == '0));
endmodule

// File: rtl/pwm_tb_period.sv
module pwm_tb_period #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CNT_W-1:0] wdata,
   input  logic             immediate,
   input  logic             zero_evt,
   output logic [CNT_W-1:0] active
);
   logic [CNT_W-1:0] held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held   <= '0;
         active <= '0;
      end else begin
         if (we) held <= wdata;
         if (we && (immediate || zero_evt)) active <= wdata;
         else if (zero_evt && !immediate)   active <= held;
      end
   end

   assert_imm_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (we && immediate) |=> (active == $past(wdata)));
   assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!zero_evt && !(we && immediate)) |=> $stable(active));
endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
   import pwm_tb_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  tb_mode_e         mode,
   input  logic [CNT_W-1:0] active,
   output logic [CNT_W-1:0] cnt,
   output logic             dir_up,
   output logic             evt_zero,
   output logic             evt_prd
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_nx;
   logic             dir_nx;
   logic             running;

   assign running  = (mode != MODE_HOLD);
   assign evt_zero = tick && running && (cnt == '0);
   assign evt_prd  = tick && running && (cnt == active);

   always_comb begin
      cnt_nx = cnt;
      dir_nx = dir_up;
      if (tick) begin
         unique case (mode)
            MODE_UP: begin
               dir_nx = 1'b1;
               cnt_nx = (cnt >= active) ? '0 : cnt + ONE;
            end
            MODE_DOWN: begin
               dir_nx = 1'b0;
               cnt_nx = (cnt == '0) ? active : cnt - ONE;
            end
            MODE_UPDN: begin
               if (dir_up) begin
                  if (cnt >= active) begin
                     dir_nx = 1'b0;
                     cnt_nx = (cnt == '0) ? '0 : cnt - ONE;
                  end else begin
                     cnt_nx = cnt + ONE;
                  end
               end else begin
                  if (cnt == '0) begin
                     dir_nx = 1'b1;
                     cnt_nx = (active == '0) ? '0 : ONE;
                  end else begin
                     cnt_nx = cnt - ONE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         dir_up <= 1'b1;
      end else begin
         cnt    <= cnt_nx;
         dir_up <= dir_nx;
      end
   end

   assert_up_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode == MODE_UP && cnt < active) |=> (cnt == $past(cnt) + ONE));
   assert_down_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode == MODE_DOWN && cnt == '0) |=> (cnt == $past(active)));
   assert_updn_turn_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode == MODE_UPDN && dir_up && cnt >= active && cnt != '0)
      |=> (!dir_up && cnt == $past(cnt) - ONE));
   assert_hold_still_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_HOLD) |=> ($stable(cnt) && $stable(dir_up)));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
   import pwm_tb_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_we,
   input  logic [15:0]      ctrl_wdata,
   input  logic             prd_we,
   input  logic [CNT_W-1:0] prd_wdata,
   output logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             dir_up,
   output logic             evt_zero,
   output logic             evt_prd
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("pwm_timebase: CNT_W must lie in 2..32");
      end
   endgenerate

   tb_mode_e         mode_q;
   logic             imm_q;
   logic [DIV_W-1:0] ck_q;
   logic [DIV_W-1:0] hs_q;
   logic [CNT_W-1:0] active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_HOLD;
         imm_q  <= 1'b0;
         ck_q   <= '0;
         hs_q   <= '0;
      end else if (ctrl_we) begin
         mode_q <= tb_mode_e'(ctrl_wdata[MODE_LSB +: 2]);
         imm_q  <= ctrl_wdata[LOAD_BIT];
         ck_q   <= ctrl_wdata[CK_LSB +: DIV_W];
         hs_q   <= ctrl_wdata[HS_LSB +: DIV_W];
      end
   end

   pwm_tb_prescaler #(.DIV_W(DIV_W)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (ctrl_we),
      .ck_sel  (ck_q),
      .hs_sel  (hs_q),
      .tick    (tick)
   );

   pwm_tb_period #(.CNT_W(CNT_W)) u_period (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (prd_we),
      .wdata     (prd_wdata),
      .immediate (imm_q),
      .zero_evt  (evt_zero),
      .active    (active)
   );

   pwm_tb_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .mode     (mode_q),
      .active   (active),
      .cnt      (cnt),
      .dir_up   (dir_up),
      .evt_zero (evt_zero),
      .evt_prd  (evt_prd)
   );

   assert_evt_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_zero || evt_prd) |-> tick);
   assert_hold_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_HOLD) |-> !(evt_zero || evt_prd));
   assert_collision_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_zero && prd_we) |=> (active == $past(prd_wdata)));
endmodule

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ctrl_we = 1'b0;
   logic [15:0]  ctrl_wdata = '0;
   logic         prd_we = 1'b0;
   logic [W-1:0] prd_wdata = '0;
   logic         tick, dir_up, evt_zero, evt_prd;
   logic [W-1:0] cnt;

   int errors = 0;
   int checks = 0;
   string cur_req = "R1";
   bit comparing = 1'b0;

   always #5 clk = ~clk;

   pwm_timebase #(.CNT_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .prd_we(prd_we), .prd_wdata(prd_wdata), .tick(tick), .cnt(cnt),
      .dir_up(dir_up), .evt_zero(evt_zero), .evt_prd(evt_prd)
   );

   // behavioural reference
   int m_mode, m_imm, m_ck, m_hs, m_pc, m_cnt, m_dir, m_act, m_sh;

   function automatic int m_ratio();
      return (1 << m_ck) * ((m_hs == 0) ? 1 : 2 * m_hs);
   endfunction
   function automatic bit m_tick();
      return m_pc == m_ratio() - 1;
   endfunction
   function automatic bit m_evz();
      return m_tick() && m_mode != 3 && m_cnt == 0;
   endfunction
   function automatic bit m_evp();
      return m_tick() && m_mode != 3 && m_cnt == m_act;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 3; m_imm = 0; m_ck = 0; m_hs = 0; m_pc = 0;
         m_cnt = 0; m_dir = 1; m_act = 0; m_sh = 0;
      end else begin
         automatic bit t = m_tick();
         automatic bit z = m_evz();
         automatic int nc = m_cnt;
         automatic int nd = m_dir;
         if (t) begin
            case (m_mode)
               0: begin nd = 1; nc = (m_cnt >= m_act) ? 0 : m_cnt + 1; end
               1: begin nd = 0; nc = (m_cnt == 0) ? m_act : m_cnt - 1; end
               2: begin
                  if (m_dir == 1) begin
                     if (m_cnt >= m_act) begin nd = 0; nc = (m_cnt == 0) ? 0 : m_cnt - 1; end
                     else nc = m_cnt + 1;
                  end else begin
                     if (m_cnt == 0) begin nd = 1; nc = (m_act == 0) ? 0 : 1; end
                     else nc = m_cnt - 1;
                  end
               end
               default: ;
            endcase
         end
         if (prd_we && (m_imm == 1 || z)) m_act = prd_wdata;
         else if (z && m_imm == 0) m_act = m_sh;
         if (prd_we) m_sh = prd_wdata;
         m_cnt = nc; m_dir = nd;
         m_pc = ctrl_we ? 0 : (t ? 0 : m_pc + 1);
         if (ctrl_we) begin
            m_mode = ctrl_wdata[1:0]; m_imm = ctrl_wdata[3];
            m_hs = ctrl_wdata[9:7];   m_ck = ctrl_wdata[12:10];
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (comparing) begin
         chk(cur_req, cnt, m_cnt, "cnt");
         chk(cur_req, dir_up, m_dir, "dir_up");
         chk("R2", tick, m_tick(), "tick");
         chk("R11", evt_zero, m_evz(), "evt_zero");
         chk("R11", evt_prd, m_evp(), "evt_prd");
      end
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ctrl_we = 1'b0; prd_we = 1'b0;
      end
   endtask
   task automatic wr_ctrl(input logic [15:0] v);
      @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v; prd_we = 1'b0;
      @(negedge clk); ctrl_we = 1'b0;
   endtask
   task automatic wr_prd(input int v);
      @(negedge clk); prd_we = 1'b1; prd_wdata = W'(v); ctrl_we = 1'b0;
      @(negedge clk); prd_we = 1'b0;
   endtask

   // control words: mode[1:0], immediate bit3, H at 9:7, C at 12:10
   initial begin
      int n;
      int mx;
      repeat (3) @(negedge clk);
      chk("R1", cnt, 0, "cnt in reset");
      chk("R1", dir_up, 1, "dir_up in reset");
      chk("R1", evt_zero | evt_prd, 0, "events in reset");
      rst_n = 1'b1;
      @(negedge clk);
      comparing = 1'b1;
      cyc(3);

      cur_req = "R9";
      wr_ctrl(16'h000B);
      wr_prd(5);
      cyc(2);
      cur_req = "R4";
      wr_ctrl(16'h0008);
      cyc(20);

      cur_req = "R3";
      @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = 16'h0508;
      n = 0;
      do begin @(negedge clk); ctrl_we = 1'b0; n++; end while (!tick);
      chk("R3", n, 8, "cycles to first tick");
      cur_req = "R2";
      n = 0;
      do begin @(negedge clk); n++; end while (!tick);
      chk("R2", n, 8, "tick spacing C=1 H=2");
      cyc(40);
      @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = 16'h1F88;
      n = 0;
      do begin @(negedge clk); ctrl_we = 1'b0; n++; end while (!tick && n < 3000);
      n = 0;
      do begin @(negedge clk); n++; end while (!tick && n < 3000);
      chk("R2", n, 1792, "tick spacing C=7 H=7");

      cur_req = "R5";
      wr_ctrl(16'h0009);
      cyc(20);
      cur_req = "R6";
      wr_ctrl(16'h000A);
      cyc(25);
      cur_req = "R7";
      wr_ctrl(16'h000B);
      cyc(10);

      cur_req = "R8";
      wr_ctrl(16'h0000);
      cyc(2);
      wr_prd(3);
      mx = 0;
      while (!evt_zero) begin
         if (cnt > mx) mx = cnt;
         @(negedge clk);
      end
      chk("R8", mx, 5, "top before transfer");
      cyc(1);
      mx = 0;
      for (int i = 0; i < 12; i++) begin @(negedge clk); if (cnt > mx) mx = cnt; end
      chk("R8", mx, 3, "top after transfer");

      cur_req = "R10";
      wr_prd(7);
      while (!m_evz()) @(negedge clk);
      prd_we = 1'b1; prd_wdata = W'(2);
      @(negedge clk); prd_we = 1'b0;
      mx = 0;
      for (int i = 0; i < 12; i++) begin @(negedge clk); if (cnt > mx) mx = cnt; end
      chk("R10", mx, 2, "top after colliding write");

      comparing = 1'b0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1000000;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule